// File: doc/BRIEF.md
# Seconds Countdown Alarm

This block counts down a relative interval in seconds and raises a sticky pending flag when the interval runs out. The host writes an interval through a small register port, turns counting on, and the count drops by one on each one-second tick pulse. The tick is supplied from outside the block. When the count steps from one to zero, the pending flag sets, and the count then stays at zero.

The pending flag feeds two outputs. An interrupt line is driven when the interrupt enable is set. A wake line is driven when the wake setting is set. The two enables are independent of each other. Software clears the flag by writing a one to the status bit. Software can read the remaining count at any time.

To reprogram the alarm, software disables counting, writes zero to the interval register, waits, then writes the new interval and enables counting again. Loading zero never counts as an expiry, so this sequence cannot raise a stale event.

Top module: `countdown_alarm`

## Requirements
- R1: After reset the count, pending flag, run bit, interrupt enable and wake setting are all zero, so `irq` and `wake` are low and every register reads zero.
- R2: A write to offset 0 (interval) copies `wdata` into the count on the next clock edge. The copy is visible at offset 1 (remaining count), and the write leaves the pending flag unchanged. Offset 0 reads as zero.
- R3: The run bit is bit 0 of offset 2. While it is 1, each cycle with `secTick` high lowers a nonzero count by exactly one. While it is 0, or when `secTick` is low, the count keeps its value.
- R4: When the count goes from 1 to 0 through a tick, the pending flag sets on the same edge. A count of zero stays zero under further ticks. Loading zero does not set pending.
- R5: Bit 0 of offset 4 reads the pending flag. Writing a 1 to that bit clears the flag, and writing a 0 leaves it unchanged.
- R6: On an edge where an expiry and a status clear coincide, the flag ends up set. On an edge where an interval write and a tick coincide, the written value is loaded and no decrement happens.
- R7: `irq` is high exactly when the pending flag and the interrupt enable (bit 0 of offset 3) are both 1.
- R8: `wake` is high exactly when the pending flag and the wake setting (bit 0 of offset 5) are both 1. This does not depend on the interrupt enable.
- R9: `rdata` is combinational from `addr`. Offsets 2, 3 and 5 read back their bit 0, and offsets 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-cycle pulse once per second |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq | output | 1 | Pending flag gated by interrupt enable |
| wake | output | 1 | Pending flag gated by wake setting |

## Verification
The bench targets the following corner cases:

- **Load of zero with a tick in the same cycle.** A design that treats zero as an expiry would raise a stale interrupt in the middle of a reprogramming sequence.
- **Status clear coinciding with an expiry.** Letting the clear win would lose an alarm without any trace.
- **Interval write coinciding with a tick.** Decrementing the new value here would shorten the interval by one second.
- **Ticks after reaching zero.** A counter that wraps would run for another 2^32 seconds.
- **Status write of zero.** A design that decodes the write as a plain store rather than write-one-to-clear would drop the flag.
- **Wake with the interrupt enable off.** A wake tied to the interrupt enable would not wake the system.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int OFS_INTERVAL = 0;
  localparam int OFS_REMAIN   = 1;
  localparam int OFS_RUN      = 2;
  localparam int OFS_IRQEN    = 3;
  localparam int OFS_STATUS   = 4;
  localparam int OFS_WAKE     = 5;

  typedef struct packed {
    logic load;
    logic step;
    logic clear;
  } alarmStrobe_t;
endpackage

// File: rtl/alarm_datapath.sv
module alarm_datapath
  import alarm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  alarmStrobe_t     strb,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] countQ,
  output logic             pendingQ
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic isZero;
  logic expire;

  assign isZero = (countQ == '0);
  assign expire = strb.step && !strb.load && (countQ == ONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (strb.load) begin
      countQ <= loadVal;
    end else if (strb.step && !isZero) begin
      countQ <= countQ - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendingQ <= 1'b0;
    end else if (expire) begin
      pendingQ <= 1'b1;
    end else if (strb.clear) begin
      pendingQ <= 1'b0;
    end
  end

  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> countQ == $past(loadVal)); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.step) |=> $stable(countQ)); // R3
  AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (isZero && !strb.load) |=> countQ == '0); // R4
  AST_EXPIRY_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !strb.load && countQ == ONE) |=> (pendingQ && countQ == '0)); // R4
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (pendingQ && !strb.clear) |=> pendingQ); // R5
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clear && strb.step && !strb.load && countQ == ONE) |=> pendingQ); // R6
endmodule

// File: rtl/alarm_ctrl.sv
module alarm_ctrl
  import alarm_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] countVal,
  input  logic              pendingVal,
  output alarmStrobe_t      strb,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              wake
);
  logic runQ;
  logic irqEnQ;
  logic wakeCfgQ;
  logic hitRun, hitIrqEn, hitWake;

  assign hitRun   = wrEn && (addr == ADDR_W'(OFS_RUN));
  assign hitIrqEn = wrEn && (addr == ADDR_W'(OFS_IRQEN));
  assign hitWake  = wrEn && (addr == ADDR_W'(OFS_WAKE));

  assign strb.load  = wrEn && (addr == ADDR_W'(OFS_INTERVAL));
  assign strb.step  = secTick && runQ;
  assign strb.clear = wrEn && (addr == ADDR_W'(OFS_STATUS)) && wdata[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ     <= 1'b0;
      irqEnQ   <= 1'b0;
      wakeCfgQ <= 1'b0;
    end else begin
      if (hitRun)   runQ     <= wdata[0];
      if (hitIrqEn) irqEnQ   <= wdata[0];
      if (hitWake)  wakeCfgQ <= wdata[0];
    end
  end

  always_comb begin
    rdata = '0;
    case (int'(addr))
      OFS_REMAIN: rdata = countVal;
      OFS_RUN:    rdata[0] = runQ;
      OFS_IRQEN:  rdata[0] = irqEnQ;
      OFS_STATUS: rdata[0] = pendingVal;
      OFS_WAKE:   rdata[0] = wakeCfgQ;
      default:    rdata = '0;
    endcase
  end

  assign irq  = pendingVal && irqEnQ;
  assign wake = pendingVal && wakeCfgQ;

  AST_IRQ_OFF_AFTER_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (hitIrqEn && !wdata[0]) |=> !irq); // R7
  AST_WAKE_FOLLOWS_CFG: assert property (@(posedge clk) disable iff (!rstN)
    (hitWake && wdata[0] && pendingVal && !strb.clear) |=> wake); // R8
  AST_NO_STEP_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    (hitRun && !wdata[0]) |=> !strb.step); // R3
endmodule

// File: rtl/countdown_alarm.sv
module countdown_alarm
  import alarm_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              wake
);
  alarmStrobe_t      strb;
  logic [DATA_W-1:0] countQ;
  logic              pendingQ;

  alarm_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .secTick(secTick), .wrEn(wrEn), .addr(addr),
    .wdata(wdata), .countVal(countQ), .pendingVal(pendingQ), .strb(strb),
    .rdata(rdata), .irq(irq), .wake(wake)
  );

  alarm_datapath #(.CNT_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .loadVal(wdata),
    .countQ(countQ), .pendingQ(pendingQ)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (!irq && !wake)); // R1
endmodule

// File: tb/countdown_alarm_tb_top.sv
module countdown_alarm_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        secTick = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, wake;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic done = 1'b0;

  logic [31:0] mCnt;
  logic mPend, mRun, mIrqEn, mWake;

  countdown_alarm dut_i (
    .clk(clk), .rstN(rstN), .secTick(secTick), .wrEn(wrEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .wake(wake)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: act=%0d exp<=150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string req);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  function automatic logic [31:0] nextCnt(input logic ld, input logic [31:0] d,
                                          input logic stp, input logic [31:0] c);
    if (ld) return d;
    if (stp && c != 0) return c - 1;
    return c;
  endfunction

  function automatic logic nextPend(input logic ld, input logic stp, input logic clr,
                                    input logic [31:0] c, input logic p);
    if (!ld && stp && c == 1) return 1'b1;
    if (clr) return 1'b0;
    return p;
  endfunction

  task automatic step(input logic w, input logic [2:0] a, input logic [31:0] d, input logic t);
    logic ld, stp, clr;
    wrEn = w; addr = a; wdata = d; secTick = t;
    ld  = w && a == 3'd0;
    stp = t && mRun;
    clr = w && a == 3'd4 && d[0];
    @(posedge clk);
    mPend = nextPend(ld, stp, clr, mCnt, mPend);
    mCnt  = nextCnt(ld, d, stp, mCnt);
    if (w && a == 3'd2) mRun = d[0];
    if (w && a == 3'd3) mIrqEn = d[0];
    if (w && a == 3'd5) mWake = d[0];
    #1;
    wrEn = 1'b0; secTick = 1'b0;
    rd(3'd1, mCnt, "R3 count");
    rd(3'd4, {31'd0, mPend}, "R5 pending");
    chk("R7 irq", {31'd0, irq}, {31'd0, mPend & mIrqEn});
    chk("R8 wake", {31'd0, wake}, {31'd0, mPend & mWake});
    @(negedge clk);
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd2024);
    mCnt = 0; mPend = 0; mRun = 0; mIrqEn = 0; mWake = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    for (int a = 0; a < 8; a++) rd(3'(a), 32'd0, "R1 reset read");
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 wake", {31'd0, wake}, 32'd0);

    step(1, 3'd0, 32'd3, 0);
    rd(3'd1, 32'd3, "R2 load copy");
    rd(3'd0, 32'd0, "R2 interval reads zero");
    step(1, 3'd2, 32'd1, 0);
    rd(3'd2, 32'd1, "R9 run readback");
    step(0, 3'd0, 0, 1);
    step(0, 3'd0, 0, 0);
    rd(3'd1, 32'd2, "R3 one tick one decrement");
    step(0, 3'd0, 0, 1);
    rd(3'd4, 32'd0, "R4 no pending before zero");
    step(0, 3'd0, 0, 1);
    rd(3'd4, 32'd1, "R4 pending at expiry");
    chk("R7 irq masked", {31'd0, irq}, 32'd0);
    step(1, 3'd5, 32'd1, 0);
    chk("R8 wake without irq enable", {31'd0, wake}, 32'd1);
    step(1, 3'd3, 32'd1, 0);
    chk("R7 irq enabled", {31'd0, irq}, 32'd1);
    step(0, 3'd0, 0, 1);
    rd(3'd1, 32'd0, "R4 holds at zero");
    step(1, 3'd4, 32'd0, 0);
    rd(3'd4, 32'd1, "R5 write zero no effect");
    step(1, 3'd0, 32'd9, 0);
    rd(3'd4, 32'd1, "R2 load keeps pending");
    step(1, 3'd4, 32'd1, 0);
    rd(3'd4, 32'd0, "R5 write one clears");
    step(1, 3'd0, 32'd0, 1);
    rd(3'd4, 32'd0, "R4 load zero no expiry");
    step(1, 3'd0, 32'd1, 0);
    step(1, 3'd4, 32'd1, 1);
    rd(3'd4, 32'd1, "R6 expiry beats clear");
    step(1, 3'd0, 32'd5, 1);
    rd(3'd1, 32'd5, "R6 load beats tick");
    step(1, 3'd2, 32'd0, 0);
    step(0, 3'd0, 0, 1);
    rd(3'd1, 32'd5, "R3 stopped holds");
    rd(3'd6, 32'd0, "R9 unused offset");
    rd(3'd7, 32'd0, "R9 unused offset");
    rd(3'd3, 32'd1, "R9 irq enable readback");
    rd(3'd5, 32'd1, "R9 wake readback");

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] d;
      logic [2:0] a;
      d = ($urandom % 8 == 0) ? $urandom : ($urandom % 6);
      a = 3'($urandom % 8);
      step(($urandom % 2) == 0, a, d, ($urandom % 3) != 0);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule